// File: doc/BRIEF.md
# Descriptor-Based DMA Channel Engine

This block is a multi-channel DMA engine. It keeps no per-channel registers. Each channel's control descriptor sits in a table in shared RAM. The table starts at `tbl_base`, and each channel's entry takes 16 bytes. A channel is started by a software trigger or by a peripheral interrupt cause, each given with a 7-bit channel number.

When a channel is started, the engine runs a fixed sequence on one memory master port:
- It reads the channel's descriptor into a working register set.
- It moves data units, each one a read from the source address followed by a write to the destination address.
- It writes the updated descriptor back to the table.

When the channel's count runs out, the engine either pulses a completion interrupt tagged with the channel number, or queues a linked channel. A chain of linked channels therefore runs one after another from a single trigger.

Triggers that arrive while the engine is busy are held in pending bitmaps. Linked channels are served before triggered channels. Within each group, the lowest channel number is served first. An access whose address does not suit the unit size is never issued. Instead the channel is abandoned and an error pulse is raised.

Top module: `desc_dma_engine`

## Requirements
- R1: For channel c, the descriptor is four 32-bit words read in the order +0, +4, +8, +12 from `tbl_base + 16*c`. The words hold: source address; destination address; count in bits 15:0 with block size in bits 31:16; and the control word. After the data units, words +0, +4 and +8 are written back in that order, with the control word left untouched.
- R2: The control word bits 3:2 give the unit size: 0 for 8 bits, 1 for 16 bits, 2 for 32 bits. This code appears on `mem_size` for data accesses; descriptor accesses always use code 2. Sub-word data travels in the low bits of the data bus, so an 8-bit unit changes exactly one byte of memory.
- R3: Mode 0 (control bits 1:0) moves one unit per trigger and lowers the count by one.
- R4: Mode 1 moves a number of units equal to the count on one trigger, leaving the count at zero.
- R5: Mode 2 moves one block of block-size units per trigger (a block size of zero is taken as one) and lowers the count by one per block.
- R6: Control bits 5:4 (source) and 7:6 (destination) independently select hold (0), increment (1) or decrement (2). The step is 1, 2 or 4 bytes, following the unit size, and applies after each unit.
- R7: In modes 1 and 2, control bit 8 (source) or bit 9 (destination) makes the written-back address equal the value it had when this trigger's run began.
- R8: When the count reaches zero and the link is disabled, and control bit 18 is set, `irq_pulse` is high for exactly one cycle with `irq_chan` naming the channel. This happens after the descriptor write-back.
- R9: When the count reaches zero and control bit 10 is set, the channel in control bits 17:11 is queued instead of any interrupt. Queued linked channels are served before any pending triggered channel.
- R10: Among pending channels of the same kind, the lowest channel number is served first.
- R11: A trigger on a channel whose stored count is zero causes only the four descriptor reads: no data access, no write-back and no interrupt.
- R12: Once `mem_req` is raised, it stays high with address, write flag, size and write data unchanged until the cycle in which `mem_ack` is high. After reset `mem_req`, `irq_pulse` and `err_pulse` are low.
- R13: A 16-bit unit at an odd address, a 32-bit unit at an address that is not a multiple of four, or size code 3 is never put on the port. Instead `err_pulse` is high for one cycle with `err_chan` naming the channel, and the channel stops with its descriptor in RAM unchanged.
- R14: A software and a hardware trigger in the same cycle on different channels are both accepted and both served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| tbl_base | input | 32 | Byte address of descriptor table entry 0 |
| sw_trig | input | 1 | Software trigger strobe, one cycle |
| sw_chan | input | 7 | Channel started by the software trigger |
| hw_trig | input | 1 | Hardware (interrupt cause) trigger strobe |
| hw_chan | input | 7 | Channel started by the hardware trigger |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_size | output | 2 | Access size code: 0 byte, 1 halfword, 2 word |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Write data, right-justified |
| mem_rdata | input | 32 | Read data, right-justified, valid with ack |
| mem_ack | input | 1 | Access completes in this cycle |
| irq_pulse | output | 1 | One-cycle completion interrupt |
| irq_chan | output | 7 | Channel that completed |
| err_pulse | output | 1 | One-cycle alignment error |
| err_chan | output | 7 | Channel abandoned on error |

## Verification
On every cycle, the bound checker watches several protocol properties:
- the memory port holds its request and payload stable while waiting for an acknowledge;
- no illegal size code and no misaligned address ever reaches the port;
- interrupt and error pulses last one cycle, and neither overlaps a bus request;
- a link hand-off never comes with an interrupt.

Other properties depend on RAM contents and on the order of events, so only the directed scenarios can show them:
- the data actually moved and the written-back addresses and counts for each mode and address-step choice;
- address restore;
- the silence of a channel whose count is exhausted;
- the order in which linked and simultaneously triggered channels complete.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 16;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOAD, ST_EVAL, ST_READ, ST_WRITE, ST_STORE, ST_FINISH
  } seq_state_e;

  localparam logic [1:0] MODE_ONE   = 2'd0;
  localparam logic [1:0] MODE_RUN   = 2'd1;
  localparam logic [1:0] MODE_BLOCK = 2'd2;

  localparam logic [1:0] SZ_WORD = 2'd2;

  localparam logic [1:0] AC_INC = 2'd1;
  localparam logic [1:0] AC_DEC = 2'd2;

  // control word field positions
  localparam int CF_MODE = 0;
  localparam int CF_SIZE = 2;
  localparam int CF_SACT = 4;
  localparam int CF_DACT = 6;
  localparam int CF_SRST = 8;
  localparam int CF_DRST = 9;
  localparam int CF_LEN  = 10;
  localparam int CF_LCH  = 11;
  localparam int CF_IEN  = 18;

  localparam int DESC_SHIFT = 4;

  function automatic logic [ADDR_W-1:0] unit_bytes(input logic [1:0] sz);
    return ADDR_W'(1) << sz;
  endfunction

  function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a,
                                                  input logic [1:0] act,
                                                  input logic [1:0] sz);
    case (act)
      AC_INC:  return a + unit_bytes(sz);
      AC_DEC:  return a - unit_bytes(sz);
      default: return a;
    endcase
  endfunction

  function automatic logic align_ok(input logic [ADDR_W-1:0] a, input logic [1:0] sz);
    case (sz)
      2'd0:    return 1'b1;
      2'd1:    return ~a[0];
      2'd2:    return a[1:0] == 2'b00;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] fit_data(input logic [DATA_W-1:0] d,
                                                 input logic [1:0] sz);
    case (sz)
      2'd0:    return {{(DATA_W-8){1'b0}}, d[7:0]};
      2'd1:    return {{(DATA_W-16){1'b0}}, d[15:0]};
      default: return d;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] desc_addr(input logic [ADDR_W-1:0] base,
                                                  input logic [ADDR_W-1:0] ch,
                                                  input logic [1:0] word);
    return base + (ch << DESC_SHIFT) + {{(ADDR_W-4){1'b0}}, word, 2'b00};
  endfunction
endpackage

// File: rtl/dma_arb.sv
module dma_arb #(
  parameter int NUM_CH = 128,
  parameter int CH_W   = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sw_trig,
  input  logic [CH_W-1:0] sw_ch,
  input  logic            hw_trig,
  input  logic [CH_W-1:0] hw_ch,
  input  logic            link_set,
  input  logic [CH_W-1:0] link_ch,
  input  logic            grant,
  output logic            pick_valid,
  output logic [CH_W-1:0] pick_ch
);
  logic [NUM_CH-1:0] trig_q;
  logic [NUM_CH-1:0] link_q;
  logic              from_link;

  function automatic logic [CH_W-1:0] lowest(input logic [NUM_CH-1:0] v);
    logic [CH_W-1:0] r;
    r = '0;
    for (int i = NUM_CH - 1; i >= 0; i--)
      if (v[i]) r = CH_W'(i);
    return r;
  endfunction

  assign from_link  = |link_q;
  assign pick_valid = from_link | (|trig_q);
  assign pick_ch    = from_link ? lowest(link_q) : lowest(trig_q);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_pend
    logic set_t, set_l, clr_t, clr_l;
    assign set_t = (sw_trig && sw_ch == CH_W'(g)) || (hw_trig && hw_ch == CH_W'(g));
    assign set_l = link_set && link_ch == CH_W'(g);
    assign clr_t = grant && !from_link && pick_ch == CH_W'(g);
    assign clr_l = grant && from_link && pick_ch == CH_W'(g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        trig_q[g] <= 1'b0;
        link_q[g] <= 1'b0;
      end else begin
        trig_q[g] <= set_t | (trig_q[g] & ~clr_t);
        link_q[g] <= set_l | (link_q[g] & ~clr_l);
      end
    end
  end
endmodule

// File: rtl/dma_port.sv
module dma_port #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [AW-1:0] addr,
  input  logic          we,
  input  logic [1:0]    size,
  input  logic [DW-1:0] wdata,
  output logic          done,
  output logic          mem_req,
  output logic          mem_we,
  output logic [1:0]    mem_size,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack
);
  assign done = mem_req & mem_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_size  <= '0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else if (go) begin
      mem_req   <= 1'b1;
      mem_we    <= we;
      mem_size  <= size;
      mem_addr  <= addr;
      mem_wdata <= wdata;
    end else if (done) begin
      mem_req <= 1'b0;
    end
  end
endmodule

// File: rtl/dma_seq.sv
module dma_seq import dma_pkg::*; #(
  parameter int NUM_CH = 128,
  parameter int CH_W   = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] tbl_base,
  input  logic              pick_valid,
  input  logic [CH_W-1:0]   pick_ch,
  output logic              grant,
  output logic              port_go,
  output logic [ADDR_W-1:0] port_addr,
  output logic              port_we,
  output logic [1:0]        port_size,
  output logic [DATA_W-1:0] port_wdata,
  input  logic              port_done,
  input  logic [DATA_W-1:0] port_rdata,
  output logic              link_set,
  output logic [CH_W-1:0]   link_ch,
  output logic              irq_q,
  output logic [CH_W-1:0]   irq_ch,
  output logic              err_q,
  output logic [CH_W-1:0]   err_ch
);
  seq_state_e        st;
  logic              wait_q;
  logic [CH_W-1:0]   ch;
  logic [1:0]        idx;
  logic [ADDR_W-1:0] src, dst, src0, dst0;
  logic [CNT_W-1:0]  cnt, bsz, left;
  logic [1:0]        mode, sz, sact, dact;
  logic              srst, drst, lnk_en, irq_en;
  logic [CH_W-1:0]   lnk_ch;
  logic [DATA_W-1:0] data_q;

  logic              multi, last_unit, misal, acc_state;
  logic [CNT_W-1:0]  units_init, cnt_dec;
  logic [ADDR_W-1:0] src_nxt, dst_nxt, tbl_addr;

  assign multi     = (mode == MODE_RUN) || (mode == MODE_BLOCK);
  assign last_unit = (left == CNT_W'(1));
  assign acc_state = (st == ST_LOAD) || (st == ST_READ) || (st == ST_WRITE) || (st == ST_STORE);
  assign misal     = !wait_q && (((st == ST_READ) && !align_ok(src, sz)) ||
                                 ((st == ST_WRITE) && !align_ok(dst, sz)));
  assign port_go   = acc_state && !wait_q && !misal;
  assign grant     = (st == ST_IDLE) && pick_valid;
  assign tbl_addr  = desc_addr(tbl_base, ADDR_W'(ch), idx);

  always_comb begin
    case (mode)
      MODE_RUN:   units_init = cnt;
      MODE_BLOCK: units_init = (bsz == '0) ? CNT_W'(1) : bsz;
      default:    units_init = CNT_W'(1);
    endcase
    cnt_dec = (mode == MODE_BLOCK) ? CNT_W'(last_unit) : CNT_W'(1);
    src_nxt = (last_unit && multi && srst) ? src0 : step_addr(src, sact, sz);
    dst_nxt = (last_unit && multi && drst) ? dst0 : step_addr(dst, dact, sz);
  end

  always_comb begin
    port_addr  = tbl_addr;
    port_we    = 1'b0;
    port_size  = SZ_WORD;
    port_wdata = '0;
    case (st)
      ST_READ: begin
        port_addr = src;
        port_size = sz;
      end
      ST_WRITE: begin
        port_addr  = dst;
        port_size  = sz;
        port_we    = 1'b1;
        port_wdata = data_q;
      end
      ST_STORE: begin
        port_we = 1'b1;
        case (idx)
          2'd0:    port_wdata = src;
          2'd1:    port_wdata = dst;
          default: port_wdata = {bsz, cnt};
        endcase
      end
      default: ;
    endcase
  end

  assign link_set = (st == ST_FINISH) && (cnt == '0) && lnk_en;
  assign link_ch  = lnk_ch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; wait_q <= 1'b0; ch <= '0; idx <= '0;
      src <= '0; dst <= '0; src0 <= '0; dst0 <= '0;
      cnt <= '0; bsz <= '0; left <= '0;
      mode <= '0; sz <= '0; sact <= '0; dact <= '0;
      srst <= 1'b0; drst <= 1'b0; lnk_en <= 1'b0; irq_en <= 1'b0; lnk_ch <= '0;
      data_q <= '0;
      irq_q <= 1'b0; irq_ch <= '0; err_q <= 1'b0; err_ch <= '0;
    end else begin
      irq_q <= 1'b0;
      err_q <= 1'b0;
      if (port_go) wait_q <= 1'b1;
      case (st)
        ST_IDLE: if (pick_valid) begin
          ch  <= pick_ch;
          idx <= '0;
          st  <= ST_LOAD;
        end
        ST_LOAD: if (port_done) begin
          wait_q <= 1'b0;
          case (idx)
            2'd0: src <= port_rdata;
            2'd1: dst <= port_rdata;
            2'd2: begin
              cnt <= port_rdata[CNT_W-1:0];
              bsz <= port_rdata[2*CNT_W-1:CNT_W];
            end
            default: begin
              mode   <= port_rdata[CF_MODE +: 2];
              sz     <= port_rdata[CF_SIZE +: 2];
              sact   <= port_rdata[CF_SACT +: 2];
              dact   <= port_rdata[CF_DACT +: 2];
              srst   <= port_rdata[CF_SRST];
              drst   <= port_rdata[CF_DRST];
              lnk_en <= port_rdata[CF_LEN];
              lnk_ch <= port_rdata[CF_LCH +: CH_W];
              irq_en <= port_rdata[CF_IEN];
            end
          endcase
          if (idx == 2'd3) st <= ST_EVAL;
          else idx <= idx + 2'd1;
        end
        ST_EVAL: begin
          if (cnt == '0) st <= ST_IDLE;
          else begin
            left <= units_init;
            src0 <= src;
            dst0 <= dst;
            st   <= ST_READ;
          end
        end
        ST_READ: begin
          if (misal) begin
            err_q  <= 1'b1;
            err_ch <= ch;
            st     <= ST_IDLE;
          end else if (port_done) begin
            wait_q <= 1'b0;
            data_q <= fit_data(port_rdata, sz);
            st     <= ST_WRITE;
          end
        end
        ST_WRITE: begin
          if (misal) begin
            err_q  <= 1'b1;
            err_ch <= ch;
            st     <= ST_IDLE;
          end else if (port_done) begin
            wait_q <= 1'b0;
            src    <= src_nxt;
            dst    <= dst_nxt;
            cnt    <= cnt - cnt_dec;
            left   <= left - CNT_W'(1);
            if (last_unit) begin
              idx <= '0;
              st  <= ST_STORE;
            end else begin
              st <= ST_READ;
            end
          end
        end
        ST_STORE: if (port_done) begin
          wait_q <= 1'b0;
          if (idx == 2'd2) st <= ST_FINISH;
          else idx <= idx + 2'd1;
        end
        ST_FINISH: begin
          irq_q  <= (cnt == '0) && !lnk_en && irq_en;
          irq_ch <= ch;
          st     <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/desc_dma_engine.sv
module desc_dma_engine import dma_pkg::*; #(
  parameter  int NUM_CH = 128,
  localparam int CH_W   = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] tbl_base,
  input  logic              sw_trig,
  input  logic [CH_W-1:0]   sw_chan,
  input  logic              hw_trig,
  input  logic [CH_W-1:0]   hw_chan,
  output logic              mem_req,
  output logic              mem_we,
  output logic [1:0]        mem_size,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack,
  output logic              irq_pulse,
  output logic [CH_W-1:0]   irq_chan,
  output logic              err_pulse,
  output logic [CH_W-1:0]   err_chan
);
  logic              pick_valid, grant, link_set, port_go, port_we, port_done;
  logic [CH_W-1:0]   pick_ch, link_ch;
  logic [ADDR_W-1:0] port_addr;
  logic [1:0]        port_size;
  logic [DATA_W-1:0] port_wdata;

  dma_arb #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_arb (
    .clk(clk), .rst_n(rst_n),
    .sw_trig(sw_trig), .sw_ch(sw_chan), .hw_trig(hw_trig), .hw_ch(hw_chan),
    .link_set(link_set), .link_ch(link_ch), .grant(grant),
    .pick_valid(pick_valid), .pick_ch(pick_ch)
  );

  dma_seq #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .tbl_base(tbl_base),
    .pick_valid(pick_valid), .pick_ch(pick_ch), .grant(grant),
    .port_go(port_go), .port_addr(port_addr), .port_we(port_we),
    .port_size(port_size), .port_wdata(port_wdata),
    .port_done(port_done), .port_rdata(mem_rdata),
    .link_set(link_set), .link_ch(link_ch),
    .irq_q(irq_pulse), .irq_ch(irq_chan), .err_q(err_pulse), .err_ch(err_chan)
  );

  dma_port #(.AW(ADDR_W), .DW(DATA_W)) u_port (
    .clk(clk), .rst_n(rst_n), .go(port_go), .addr(port_addr), .we(port_we),
    .size(port_size), .wdata(port_wdata), .done(port_done),
    .mem_req(mem_req), .mem_we(mem_we), .mem_size(mem_size),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack)
  );
endmodule

// File: rtl/dma_engine_chk.sv
module dma_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_req,
  input logic        mem_ack,
  input logic        mem_we,
  input logic [1:0]  mem_size,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic        irq_pulse,
  input logic        err_pulse,
  input logic        link_set
);
  // R12
  hold_until_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) &&
                            $stable(mem_size) && $stable(mem_wdata));
  // R2
  legal_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_size != 2'd3);
  // R13
  aligned_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !((mem_size == 2'd1 && mem_addr[0]) ||
                  (mem_size == 2'd2 && mem_addr[1:0] != 2'b00)));
  // R13
  err_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |=> !err_pulse);
  // R13
  err_idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> !mem_req);
  // R8
  irq_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse);
  // R8
  irq_after_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> !mem_req);
  // R9
  link_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_set |=> !irq_pulse);
endmodule

bind desc_dma_engine dma_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_ack(mem_ack),
  .mem_we(mem_we), .mem_size(mem_size), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .irq_pulse(irq_pulse), .err_pulse(err_pulse),
  .link_set(link_set)
);

// File: tb/sim_desc_dma_engine.sv
`timescale 1ns/1ps
module sim_desc_dma_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] tbl_base = 32'h800;
  logic        sw_trig = 1'b0, hw_trig = 1'b0;
  logic [6:0]  sw_chan = '0, hw_chan = '0;
  logic        mem_req, mem_we, mem_ack = 1'b0;
  logic [1:0]  mem_size;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic        irq_pulse, err_pulse;
  logic [6:0]  irq_chan, err_chan;

  desc_dma_engine u0 (.*);

  always #5 clk = ~clk;

  logic [7:0] mem [0:4095];
  int n_chk = 0, n_bad = 0;
  int lat = 0, wcnt = 0, rd_n = 0, wr_n = 0, irq_n = 0, err_n = 0;
  logic [6:0] irq_log [0:31];

  function automatic logic [31:0] rd32(input int a);
    return {mem[a+3], mem[a+2], mem[a+1], mem[a]};
  endfunction
  task automatic wr32(input int a, input logic [31:0] v);
    {mem[a+3], mem[a+2], mem[a+1], mem[a]} = v;
  endtask
  function automatic logic [31:0] mkctl(input int md, sz, sa, da, sr, dr, le, lc, ie);
    return 32'(md) | 32'(sz) << 2 | 32'(sa) << 4 | 32'(da) << 6 | 32'(sr) << 8 |
           32'(dr) << 9 | 32'(le) << 10 | 32'(lc) << 11 | 32'(ie) << 18;
  endfunction
  task automatic put_desc(input int c, input logic [31:0] s, d,
                          input int cnt, bs, input logic [31:0] ctl);
    int b;
    b = 'h800 + 16 * c;
    wr32(b, s); wr32(b + 4, d); wr32(b + 8, {16'(bs), 16'(cnt)}); wr32(b + 12, ctl);
  endtask
  task automatic chk(input string rq, input string what, input logic [31:0] act, exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  // memory model, acts away from the active edge
  initial forever begin
    int a;
    @(negedge clk);
    if (mem_ack) mem_ack = 1'b0;
    else if (mem_req) begin
      if (wcnt < lat) wcnt++;
      else begin
        wcnt = 0;
        a = int'(mem_addr[11:0]);
        if (mem_we) begin
          wr_n++;
          mem[a] = mem_wdata[7:0];
          if (mem_size >= 2'd1) mem[a+1] = mem_wdata[15:8];
          if (mem_size == 2'd2) begin mem[a+2] = mem_wdata[23:16]; mem[a+3] = mem_wdata[31:24]; end
        end else begin
          rd_n++;
          case (mem_size)
            2'd0: mem_rdata = {24'h0, mem[a]};
            2'd1: mem_rdata = {16'h0, mem[a+1], mem[a]};
            default: mem_rdata = rd32(a);
          endcase
        end
        mem_ack = 1'b1;
      end
    end
  end

  initial forever begin
    @(negedge clk);
    if (irq_pulse) begin irq_log[irq_n % 32] = irq_chan; irq_n++; end
    if (err_pulse) err_n++;
  end

  task automatic fire_sw(input int c);
    @(negedge clk); sw_trig = 1'b1; sw_chan = 7'(c);
    @(negedge clk); sw_trig = 1'b0;
  endtask
  task automatic fire_hw(input int c);
    @(negedge clk); hw_trig = 1'b1; hw_chan = 7'(c);
    @(negedge clk); hw_trig = 1'b0;
  endtask
  task automatic settle();
    repeat (300) @(negedge clk);
  endtask

  task automatic t_single();
    int r0, w0, i0;
    lat = 1;
    put_desc(3, 32'h100, 32'h200, 2, 0, mkctl(0, 2, 1, 1, 0, 0, 0, 0, 1));
    wr32('h100, 32'hA1B2C3D4); wr32('h104, 32'h11223344);
    r0 = rd_n; w0 = wr_n; i0 = irq_n;
    fire_sw(3); settle();
    chk("R3", "dst word", rd32('h200), 32'hA1B2C3D4);
    chk("R6", "src after inc", rd32('h830), 32'h104);
    chk("R6", "dst after inc", rd32('h834), 32'h204);
    chk("R3", "count", rd32('h838), 32'h1);
    chk("R1", "reads", 32'(rd_n - r0), 32'd5);
    chk("R1", "writes", 32'(wr_n - w0), 32'd4);
    chk("R8", "no irq before zero", 32'(irq_n - i0), 32'd0);
    fire_sw(3); settle();
    chk("R3", "second word", rd32('h204), 32'h11223344);
    chk("R8", "irq count", 32'(irq_n - i0), 32'd1);
    chk("R8", "irq chan", 32'(irq_log[(irq_n - 1) % 32]), 32'd3);
    r0 = rd_n; w0 = wr_n;
    fire_sw(3); settle();
    chk("R11", "reads on spent channel", 32'(rd_n - r0), 32'd4);
    chk("R11", "writes on spent channel", 32'(wr_n - w0), 32'd0);
    chk("R11", "no irq on spent channel", 32'(irq_n - i0), 32'd1);
  endtask

  task automatic t_run();
    int i0;
    lat = 2;
    put_desc(10, 32'h300, 32'h3A0, 3, 0, mkctl(1, 1, 1, 2, 1, 0, 0, 0, 1));
    mem['h300] = 8'h11; mem['h301] = 8'h11; mem['h302] = 8'h22; mem['h303] = 8'h22;
    mem['h304] = 8'h33; mem['h305] = 8'h33;
    i0 = irq_n;
    fire_sw(10); settle();
    chk("R4", "unit 0", {mem['h3A1], mem['h3A0]}, 32'h1111);
    chk("R6", "unit 1 decremented", {mem['h39F], mem['h39E]}, 32'h2222);
    chk("R6", "unit 2 decremented", {mem['h39D], mem['h39C]}, 32'h3333);
    chk("R7", "src restored", rd32('h8A0), 32'h300);
    chk("R7", "dst not restored", rd32('h8A4), 32'h39A);
    chk("R4", "count zero", rd32('h8A8), 32'h0);
    chk("R8", "irq chan 10", 32'(irq_log[(irq_n - 1) % 32]), 32'd10);
    chk("R4", "one irq", 32'(irq_n - i0), 32'd1);
  endtask

  task automatic t_block();
    int i0;
    lat = 0;
    put_desc(40, 32'h410, 32'h420, 2, 4, mkctl(2, 0, 1, 0, 0, 0, 0, 0, 1));
    mem['h410] = 8'h05; mem['h411] = 8'h06; mem['h412] = 8'h07; mem['h413] = 8'h08;
    mem['h420] = 8'h00; mem['h421] = 8'hEE;
    i0 = irq_n;
    fire_hw(40); settle();
    chk("R5", "held dst last byte", 32'(mem['h420]), 32'h08);
    chk("R2", "neighbour byte untouched", 32'(mem['h421]), 32'hEE);
    chk("R6", "src stepped by 1", rd32('hA80), 32'h414);
    chk("R6", "dst held", rd32('hA84), 32'h420);
    chk("R5", "count and size word", rd32('hA88), 32'h0004_0001);
    chk("R5", "no irq mid count", 32'(irq_n - i0), 32'd0);
  endtask

  task automatic t_link();
    int i0;
    lat = 1;
    put_desc(5, 32'h500, 32'h510, 1, 0, mkctl(0, 2, 0, 0, 0, 0, 1, 9, 1));
    put_desc(9, 32'h520, 32'h530, 1, 0, mkctl(0, 2, 0, 0, 0, 0, 0, 0, 1));
    put_desc(2, 32'h540, 32'h550, 1, 0, mkctl(0, 2, 0, 0, 0, 0, 0, 0, 1));
    wr32('h520, 32'hCAFE0009);
    i0 = irq_n;
    fire_sw(5); fire_sw(2); settle();
    chk("R9", "linked channel moved data", rd32('h530), 32'hCAFE0009);
    chk("R9", "irq count", 32'(irq_n - i0), 32'd2);
    chk("R9", "linked first", 32'(irq_log[i0 % 32]), 32'd9);
    chk("R10", "pending trigger after", 32'(irq_log[(i0 + 1) % 32]), 32'd2);
  endtask

  task automatic t_both();
    int i0;
    lat = 0;
    put_desc(20, 32'h560, 32'h570, 1, 0, mkctl(0, 2, 0, 0, 0, 0, 0, 0, 1));
    put_desc(7, 32'h580, 32'h590, 1, 0, mkctl(0, 2, 0, 0, 0, 0, 0, 0, 1));
    i0 = irq_n;
    @(negedge clk); sw_trig = 1'b1; sw_chan = 7'd20; hw_trig = 1'b1; hw_chan = 7'd7;
    @(negedge clk); sw_trig = 1'b0; hw_trig = 1'b0;
    settle();
    chk("R14", "both served", 32'(irq_n - i0), 32'd2);
    chk("R10", "lower first", 32'(irq_log[i0 % 32]), 32'd7);
    chk("R14", "higher second", 32'(irq_log[(i0 + 1) % 32]), 32'd20);
  endtask

  task automatic t_misalign();
    int r0, w0, e0, i0;
    lat = 1;
    put_desc(60, 32'h602, 32'h610, 1, 0, mkctl(0, 2, 1, 1, 0, 0, 0, 0, 1));
    r0 = rd_n; w0 = wr_n; e0 = err_n; i0 = irq_n;
    fire_sw(60); settle();
    chk("R13", "err pulse", 32'(err_n - e0), 32'd1);
    chk("R13", "err chan", 32'(err_chan), 32'd60);
    chk("R13", "only descriptor reads", 32'(rd_n - r0), 32'd4);
    chk("R13", "no writes", 32'(wr_n - w0), 32'd0);
    chk("R13", "descriptor kept", rd32('hBC0), 32'h602);
    put_desc(61, 32'h620, 32'h631, 1, 0, mkctl(0, 1, 1, 1, 0, 0, 0, 0, 1));
    r0 = rd_n; w0 = wr_n;
    fire_sw(61); settle();
    chk("R13", "odd halfword dst err", 32'(err_n - e0), 32'd2);
    chk("R13", "source read done", 32'(rd_n - r0), 32'd5);
    chk("R13", "no write on odd dst", 32'(wr_n - w0), 32'd0);
    chk("R13", "no irq on error", 32'(irq_n - i0), 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk("R12", "req low in reset", 32'(mem_req), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12", "req low after reset", 32'(mem_req), 32'd0);
    chk("R12", "irq low after reset", 32'(irq_pulse), 32'd0);
    chk("R12", "err low after reset", 32'(err_pulse), 32'd0);
    t_single();
    t_run();
    t_block();
    t_link();
    t_both();
    t_misalign();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule